// File: doc/BRIEF.md
# Partial-Scan Test Sequencer

This block runs the complete test of a logic region in which only part of the flip-flops sit on a scan chain. It produces two clock enables. One gates the chained (scanned) flip-flops and the other gates the flip-flops left off the chain. It also drives the shift/capture select and the serial chain input, and it samples the serial chain output. A single start pulse launches a fixed sequence with three parts. First, a flush pattern checks that the chain shifts correctly. Next, each stored vector gets a chain load followed by one capture cycle. Finally, the last captured response is shifted out.

The stimulus sits in three small internal memories, all loaded through one write port. These hold the primary-input word of each vector, the chain word to shift in before each vector, and the chain word expected after each capture. The response of each vector leaves the chain while the next vector's chain word enters it. As a result, the whole test takes a known number of clocks that depends only on the chain length and the vector count. Two sticky flags report a broken chain and a wrong response.

Top module: `pscan_seq`

## Requirements
- R1: After reset, busy, done, both clock enables, the mode select, the serial input and both fail flags are low.
- R2: A run opens with CHAIN_LEN+4 shift cycles, with mode select high. During these cycles the serial input carries 0,0,1,1 repeated, starting with the first shift cycle.
- R3: Whenever mode select is high, the chain clock enable is high and the non-chain clock enable is low, so the non-chain flip-flops keep their value during every shift.
- R4: Each vector gets exactly one capture cycle, in vector order. In that cycle mode select is low, both clock enables are high, and the primary-input output equals the vector's stored word.
- R5: Before each capture there are CHAIN_LEN shift cycles, and bit j of that vector's chain word is driven on the j-th of them (bit 0 first). After the last capture come CHAIN_LEN further shift cycles with the serial input at 0.
- R6: On the j-th shift after a capture, the serial output is compared with bit j of that vector's expected word. Any mismatch sets resp_fail, and the flag stays set until the next accepted start.
- R7: On flush cycle k, for k ≥ CHAIN_LEN, the serial output must equal the flush bit driven on cycle k−CHAIN_LEN. Otherwise chain_fail is set, and it stays set until the next accepted start.
- R8: busy is high for exactly (NUM_VEC+2)·CHAIN_LEN + NUM_VEC + 4 cycles. done is high for exactly one cycle, in the cycle right after busy falls.
- R9: A start pulse while busy has no effect on the run length. A start accepted while idle clears both fail flags.
- R10: Write-port select 0 writes the primary-input word, 1 writes the chain word and 2 writes the expected word, all at wr_addr. Select 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start a run (taken only when idle) |
| wr_en | input | 1 | Memory write strobe |
| wr_sel | input | 2 | Memory select: 0 input word, 1 chain word, 2 expected word, 3 none |
| wr_addr | input | VW | Vector index of the write |
| wr_data | input | DW | Write data, low bits used per memory |
| scan_out | input | 1 | Serial output of the chain |
| scan_in | output | 1 | Serial input of the chain |
| test_mode | output | 1 | 1 = shift, 0 = capture |
| scan_clk_en | output | 1 | Clock enable of chained flip-flops |
| func_clk_en | output | 1 | Clock enable of non-chained flip-flops |
| pi_out | output | PI_W | Primary-input word of the current vector |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| chain_fail | output | 1 | Sticky flush-check failure |
| resp_fail | output | 1 | Sticky response mismatch |

## Verification
The bench drives a model of the region: a shift register that captures a rotate-and-XOR of its contents and the input word, plus an accumulator clocked only by the non-chain enable. Several vector sets are swept with all expected words correct; these separate good sequencing from mis-ordered bits or misplaced captures. In a second sweep, one expected bit is corrupted in each vector in turn, which tells the position of the response compare apart from an unchecked one. A stuck serial output separates the flush check from the response check. A start pulse in mid-run and a write with select 3 show that both are ignored.

// File: rtl/pscan_pkg.sv
package pscan_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FLUSH,
        PH_LOAD,
        PH_CAPT,
        PH_DRAIN
    } phase_e;

    function automatic int total_clocks(input int chain_len, input int num_vec);
        return (num_vec + 2) * chain_len + num_vec + 4;
    endfunction

endpackage

// File: rtl/pscan_store.sv
module pscan_store #(
    parameter int W     = 6,
    parameter int DEPTH = 4,
    parameter int AW    = 2
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata = mem_q[raddr];
    end

endmodule

// File: rtl/pscan_ctrl.sv
module pscan_ctrl
    import pscan_pkg::*;
#(
    parameter int CHAIN_LEN = 6,
    parameter int NUM_VEC   = 4,
    parameter int VW        = 2,
    parameter int LW        = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          clr,
    output logic          test_mode,
    output logic          scan_clk_en,
    output logic          func_clk_en,
    output logic          load_en,
    output logic          flush_bit,
    output logic          flush_cmp,
    output logic          flush_exp,
    output logic          resp_cmp,
    output logic [VW-1:0] vec_idx,
    output logic [VW-1:0] exp_addr,
    output logic [LW-1:0] bit_idx
);

    localparam int TOTAL = total_clocks(CHAIN_LEN, NUM_VEC);
    localparam int BW    = $clog2(CHAIN_LEN + 4);
    localparam int CW    = $clog2(TOTAL + 1);

    typedef struct packed {
        phase_e        phase;
        logic [BW-1:0] bitc;
        logic [VW-1:0] vec;
        logic [CW-1:0] cyc;
        logic [1:0]    pat;
        logic [1:0]    chk;
        logic          done;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase = PH_FLUSH;
                    st_d.bitc  = '0;
                    st_d.vec   = '0;
                    st_d.cyc   = '0;
                    st_d.pat   = '0;
                    st_d.chk   = '0;
                end
            end
            PH_FLUSH: begin
                st_d.cyc = st_q.cyc + CW'(1);
                st_d.pat = st_q.pat + 2'd1;
                if (st_q.bitc >= BW'(CHAIN_LEN)) begin
                    st_d.chk = st_q.chk + 2'd1;
                end
                if (st_q.bitc == BW'(CHAIN_LEN + 3)) begin
                    st_d.phase = PH_LOAD;
                    st_d.bitc  = '0;
                end else begin
                    st_d.bitc = st_q.bitc + BW'(1);
                end
            end
            PH_LOAD: begin
                st_d.cyc = st_q.cyc + CW'(1);
                if (st_q.bitc == BW'(CHAIN_LEN - 1)) begin
                    st_d.phase = PH_CAPT;
                    st_d.bitc  = '0;
                end else begin
                    st_d.bitc = st_q.bitc + BW'(1);
                end
            end
            PH_CAPT: begin
                st_d.cyc = st_q.cyc + CW'(1);
                if (st_q.vec == VW'(NUM_VEC - 1)) begin
                    st_d.phase = PH_DRAIN;
                end else begin
                    st_d.vec   = st_q.vec + VW'(1);
                    st_d.phase = PH_LOAD;
                end
            end
            PH_DRAIN: begin
                st_d.cyc = st_q.cyc + CW'(1);
                if (st_q.bitc == BW'(CHAIN_LEN - 1)) begin
                    st_d.phase = PH_IDLE;
                    st_d.bitc  = '0;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.bitc = st_q.bitc + BW'(1);
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, bitc: '0, vec: '0, cyc: '0,
                      pat: '0, chk: '0, done: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        busy        = (st_q.phase != PH_IDLE);
        done        = st_q.done;
        clr         = (st_q.phase == PH_IDLE) && start;
        test_mode   = (st_q.phase == PH_FLUSH) || (st_q.phase == PH_LOAD)
                   || (st_q.phase == PH_DRAIN);
        scan_clk_en = busy;
        func_clk_en = (st_q.phase == PH_CAPT);
        load_en     = (st_q.phase == PH_LOAD);
        flush_bit   = (st_q.phase == PH_FLUSH) && st_q.pat[1];
        flush_cmp   = (st_q.phase == PH_FLUSH) && (st_q.bitc >= BW'(CHAIN_LEN));
        flush_exp   = st_q.chk[1];
        resp_cmp    = ((st_q.phase == PH_LOAD) && (st_q.vec != '0))
                   || (st_q.phase == PH_DRAIN);
        exp_addr    = (st_q.phase == PH_DRAIN) ? st_q.vec : st_q.vec - VW'(1);
        vec_idx     = st_q.vec;
        bit_idx     = st_q.bitc[LW-1:0];
    end

    // R4
    one_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        func_clk_en |=> !func_clk_en);

    // R8
    done_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (st_q.cyc == CW'(TOTAL)) && !busy);

    // R9
    start_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R3
    shift_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode |-> scan_clk_en && !func_clk_en);

endmodule

// File: rtl/pscan_check.sv
module pscan_check (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic scan_out,
    input  logic flush_cmp,
    input  logic flush_exp,
    input  logic resp_cmp,
    input  logic resp_exp,
    output logic chain_fail,
    output logic resp_fail
);

    typedef struct packed {
        logic chain_bad;
        logic resp_bad;
    } flag_t;

    flag_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (clr) begin
            fl_d = '0;
        end else begin
            if (flush_cmp && (scan_out != flush_exp)) begin
                fl_d.chain_bad = 1'b1;
            end
            if (resp_cmp && (scan_out != resp_exp)) begin
                fl_d.resp_bad = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign chain_fail = fl_q.chain_bad;
    assign resp_fail  = fl_q.resp_bad;

    // R7
    chain_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(chain_fail) && !$past(clr)) |-> chain_fail);

    // R6
    resp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(resp_fail) && !$past(clr)) |-> resp_fail);

endmodule

// File: rtl/pscan_seq.sv
module pscan_seq
    import pscan_pkg::*;
#(
    parameter int CHAIN_LEN = 6,
    parameter int NUM_VEC   = 4,
    parameter int PI_W      = 4,
    localparam int VW = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
    localparam int DW = (PI_W > CHAIN_LEN) ? PI_W : CHAIN_LEN
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [VW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic            scan_out,
    output logic            scan_in,
    output logic            test_mode,
    output logic            scan_clk_en,
    output logic            func_clk_en,
    output logic [PI_W-1:0] pi_out,
    output logic            busy,
    output logic            done,
    output logic            chain_fail,
    output logic            resp_fail
);

    localparam int LW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;

    logic            clr, load_en, flush_bit, flush_cmp, flush_exp, resp_cmp;
    logic [VW-1:0]   vec_idx, exp_addr;
    logic [LW-1:0]   bit_idx;
    logic [PI_W-1:0] pi_word;
    logic [CHAIN_LEN-1:0] chain_word, exp_word;

    pscan_ctrl #(
        .CHAIN_LEN(CHAIN_LEN), .NUM_VEC(NUM_VEC), .VW(VW), .LW(LW)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .busy(busy), .done(done), .clr(clr),
        .test_mode(test_mode), .scan_clk_en(scan_clk_en),
        .func_clk_en(func_clk_en), .load_en(load_en),
        .flush_bit(flush_bit), .flush_cmp(flush_cmp), .flush_exp(flush_exp),
        .resp_cmp(resp_cmp), .vec_idx(vec_idx), .exp_addr(exp_addr),
        .bit_idx(bit_idx)
    );

    pscan_store #(.W(PI_W), .DEPTH(NUM_VEC), .AW(VW)) i_pi_mem (
        .clk(clk), .we(wr_en && (wr_sel == 2'd0)), .waddr(wr_addr),
        .wdata(wr_data[PI_W-1:0]), .raddr(vec_idx), .rdata(pi_word)
    );

    pscan_store #(.W(CHAIN_LEN), .DEPTH(NUM_VEC), .AW(VW)) i_chain_mem (
        .clk(clk), .we(wr_en && (wr_sel == 2'd1)), .waddr(wr_addr),
        .wdata(wr_data[CHAIN_LEN-1:0]), .raddr(vec_idx), .rdata(chain_word)
    );

    pscan_store #(.W(CHAIN_LEN), .DEPTH(NUM_VEC), .AW(VW)) i_exp_mem (
        .clk(clk), .we(wr_en && (wr_sel == 2'd2)), .waddr(wr_addr),
        .wdata(wr_data[CHAIN_LEN-1:0]), .raddr(exp_addr), .rdata(exp_word)
    );

    pscan_check i_check (
        .clk(clk), .rst_n(rst_n), .clr(clr), .scan_out(scan_out),
        .flush_cmp(flush_cmp), .flush_exp(flush_exp),
        .resp_cmp(resp_cmp), .resp_exp(exp_word[bit_idx]),
        .chain_fail(chain_fail), .resp_fail(resp_fail)
    );

    always_comb begin
        scan_in = load_en ? chain_word[bit_idx] : flush_bit;
        pi_out  = pi_word;
    end

endmodule

// File: tb/test_pscan_seq.sv
module test_pscan_seq;

    localparam int CLK_PERIOD = 10;
    localparam int L     = 6;
    localparam int V     = 4;
    localparam int PW    = 4;
    localparam int TOTAL = (V + 2) * L + V + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [1:0] wr_addr = '0;
    logic [5:0] wr_data = '0;
    logic scan_out, scan_in, test_mode, scan_clk_en, func_clk_en;
    logic [PW-1:0] pi_out;
    logic busy, done, chain_fail, resp_fail;

    logic [L-1:0]  chain = '0;
    logic [PW-1:0] ns_reg = '0;
    logic stuck = 1'b0;

    int total = 0, bad = 0, cyc_all = 0;
    bit finished = 0;

    logic [PW-1:0] pi_w [V];
    logic [L-1:0]  ch_w [V];
    logic [L-1:0]  ex_w [V];

    int n_busy, n_func, n_over, n_flush_bad, n_done, pi_bad, cap_idx;
    logic got_cf, got_rf;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pscan_seq i_pscan_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .scan_out(scan_out), .scan_in(scan_in), .test_mode(test_mode),
        .scan_clk_en(scan_clk_en), .func_clk_en(func_clk_en),
        .pi_out(pi_out), .busy(busy), .done(done),
        .chain_fail(chain_fail), .resp_fail(resp_fail)
    );

    function automatic logic [L-1:0] resp_f(input logic [L-1:0] s, input logic [PW-1:0] p);
        return {s[L-2:0], s[L-1]} ^ {p[1:0], p};
    endfunction

    assign scan_out = stuck ? 1'b0 : chain[L-1];

    always @(posedge clk) begin
        if (scan_clk_en) begin
            if (test_mode) chain <= {chain[L-2:0], scan_in};
            else           chain <= resp_f(chain, pi_out);
        end
        if (func_clk_en) ns_reg <= ns_reg + pi_out;
    end

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc_all++;
        if (cyc_all > 100000) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=%0d", cyc_all, 100000);
            summary();
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input int addr, input logic [5:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_addr = 2'(addr); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // bench-side expected response: chain word c loaded bit 0 first
    task automatic make_set(input int seed);
        for (int v = 0; v < V; v++) begin
            logic [L-1:0] s, r;
            pi_w[v] = PW'((seed * 5 + v * 3 + 1) % 16);
            ch_w[v] = L'((seed * 11 + v * 23 + 7) % 64);
            for (int j = 0; j < L; j++) s[L-1-j] = ch_w[v][j];
            r = resp_f(s, pi_w[v]);
            for (int j = 0; j < L; j++) ex_w[v][j] = r[L-1-j];
        end
        for (int v = 0; v < V; v++) begin
            wr(2'd0, v, 6'(pi_w[v]));
            wr(2'd1, v, ch_w[v]);
            wr(2'd2, v, ex_w[v]);
        end
    endtask

    task automatic run_once(input bit poke);
        int guard;
        n_busy = 0; n_func = 0; n_over = 0; n_flush_bad = 0;
        n_done = 0; pi_bad = 0; cap_idx = 0; guard = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (1) begin
            if (busy) begin
                start = (poke && n_busy == 10);
                if (test_mode && (func_clk_en || !scan_clk_en)) n_over++;
                if (n_busy < L + 4) begin
                    if (!test_mode || scan_in != ((n_busy >> 1) & 1)) n_flush_bad++;
                end
                if (func_clk_en) begin
                    if (test_mode || !scan_clk_en) n_over++;
                    if (cap_idx < V && pi_out != pi_w[cap_idx]) pi_bad++;
                    cap_idx++; n_func++;
                end
                n_busy++;
            end
            if (done) begin
                n_done++;
                got_cf = chain_fail; got_rf = resp_fail;
                break;
            end
            guard++;
            if (guard > 2000) begin
                chk("watchdog run", guard, 0);
                break;
            end
            @(negedge clk);
        end
        start = 1'b0;
        @(negedge clk);
        if (done) n_done++;
    endtask

    task automatic good_run(input int seed, input bit poke, input string tag);
        logic [PW-1:0] ns0, sum;
        ns0 = ns_reg;
        sum = ns0;
        for (int v = 0; v < V; v++) sum = sum + pi_w[v];
        run_once(poke);
        chk({tag, " R8 busy cycles"}, n_busy, TOTAL);
        chk({tag, " R8 done pulses"}, n_done, 1);
        chk({tag, " R4 captures"}, n_func, V);
        chk({tag, " R4 capture input word"}, pi_bad, 0);
        chk({tag, " R3 enable overlap"}, n_over, 0);
        chk({tag, " R3 non-chain freeze"}, int'(ns_reg), int'(sum));
        chk({tag, " R2 flush pattern"}, n_flush_bad, 0);
        chk({tag, " R7 chain ok"}, int'(got_cf), 0);
        chk({tag, " R5 R6 response ok"}, int'(got_rf), 0);
        chk({tag, " R8 idle after"}, int'(busy), 0);
        if (seed < 0) chk("seed", seed, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 3);
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 enables", int'(scan_clk_en) + int'(func_clk_en) + int'(test_mode), 0);
        chk("R1 scan_in", int'(scan_in), 0);
        chk("R1 flags", int'(chain_fail) + int'(resp_fail), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int s = 0; s < 4; s++) begin
            make_set(s);
            good_run(s, 1'b0, "sweep");
        end

        // R6: corrupt one expected bit per vector
        make_set(7);
        for (int v = 0; v < V; v++) begin
            wr(2'd2, v, ex_w[v] ^ L'(1 << (v % L)));
            run_once(1'b0);
            chk("R6 corrupted expected sets resp_fail", int'(got_rf), 1);
            chk("R6 chain unaffected", int'(got_cf), 0);
            wr(2'd2, v, ex_w[v]);
        end

        // R7: stuck serial output
        stuck = 1'b1;
        run_once(1'b0);
        chk("R7 stuck chain sets chain_fail", int'(got_cf), 1);
        @(negedge clk);
        chk("R7 flag sticky in idle", int'(chain_fail), 1);
        stuck = 1'b0;

        // R9: flags cleared by new start, start while busy ignored
        good_run(8, 1'b1, "R9 poke");

        // R10: select 3 writes nothing
        for (int v = 0; v < V; v++) wr(2'd3, v, 6'h2A ^ 6'(v));
        good_run(9, 1'b0, "R10 sel3");

        summary();
    end

endmodule